// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic core of an 8-bit accumulator machine. A 4-bit operation code selects one of sixteen functions over the accumulator value, an index value and a memory operand. The carry input comes from a status register inside the block. The result and the updated carry, zero, negative and overflow flags leave the block combinationally in the same cycle.

The status register keeps carry, zero, interrupt-mask, decimal, break, overflow and negative in one byte, and bit 5 of that byte always reads 1. An execute strobe stores the updated arithmetic flags at the next clock edge. A separate write port loads the whole byte from outside. Interrupt-mask, decimal and break change only through that write port. Decimal arithmetic, instruction sequencing and memory access belong to the surrounding processor.

Top module: `alu8_status`

## Requirements
- R1: Op 4'h0 (add) returns A + M + C mod 256. Carry is bit 8 of the 9-bit sum. Overflow is set when A and M share a sign bit and the result sign differs from A. Z and N come from the result.
- R2: Op 4'h1 (subtract) returns A − M − (1 − C) mod 256. Carry is set when no borrow occurs. Overflow is set when A and M differ in sign and the result sign differs from A. Z and N come from the result.
- R3: Op 4'h2 compares A with M and op 4'h3 compares X with M. Carry = register ≥ M. Z and N come from the low 8 bits of the difference. The result output equals the compared register and overflow is unchanged.
- R4: Op 4'h8 (bit test) sets N from M bit 7, V from M bit 6 and Z when (A & M) is 0. The result equals A and carry is unchanged.
- R5: Ops on M: 4'h4 shifts left with bit 7 into carry, 4'h5 shifts right with bit 0 into carry, 4'h6 rotates left with the old carry entering bit 0, and 4'h7 rotates right with the old carry entering bit 7. Z and N come from the result and V is unchanged.
- R6: Ops 4'h9 (A & M), 4'hA (A | M), 4'hB (A ^ M) and 4'hF (pass M) set Z and N from the result and leave C and V unchanged.
- R7: Op 4'hC returns (A & M) >> 1 with the old carry in bit 7. New carry = result bit 6, overflow = result bit 6 XOR bit 5, and Z and N come from the result.
- R8: Op 4'hD returns (A & X) − M mod 256. Carry is set when there is no borrow, Z and N come from the result, and V is unchanged.
- R9: Op 4'hE returns (A & M) >> 1. Carry = bit 0 of (A & M), N is 0, Z comes from the result and V is unchanged.
- R10: The status byte holds C at bit 0, Z at bit 1, I at bit 2, D at bit 3, B at bit 4, a constant 1 at bit 5, V at bit 6 and N at bit 7. Reset value is 8'h22.
- R11: With the execute strobe high and no status write, the next edge stores the updated C, Z, N and V and keeps I, D and B.
- R12: A status write stores the written byte with bit 5 forced to 1 and wins over an execute strobe in the same cycle. With neither strobe high, the byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value A |
| idx_i | input | 8 | Index value X |
| opnd_i | input | 8 | Operand M |
| exec_i | input | 1 | Store updated flags at the next edge |
| st_wr_i | input | 1 | Load status byte from st_din_i |
| st_din_i | input | 8 | Status byte to load |
| result_o | output | 8 | Operation result |
| c_o | output | 1 | Updated carry |
| z_o | output | 1 | Updated zero |
| n_o | output | 1 | Updated negative |
| v_o | output | 1 | Updated overflow |
| status_o | output | 8 | Registered status byte |

## Verification
An execute strobe and a status write can arrive in the same cycle, and both target the same status register. The bench raises both together while an add operation produces a flag set that differs from the written byte. It then checks that the byte after the edge equals the written value with bit 5 set, and that none of the computed flags got through. Apart from that collision, every operation code is swept over all values of A and M under two status bytes that hold opposite carry and overflow. Each output is compared with a model computed from integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned W   = 8;
  localparam int unsigned MSB = W - 1;

  // status byte bit positions (software decodes these)
  localparam int unsigned ST_C   = 0;
  localparam int unsigned ST_Z   = 1;
  localparam int unsigned ST_I   = 2;
  localparam int unsigned ST_D   = 3;
  localparam int unsigned ST_B   = 4;
  localparam int unsigned ST_ONE = 5;
  localparam int unsigned ST_V   = 6;
  localparam int unsigned ST_N   = 7;
  localparam logic [7:0] ONE_MASK = 8'(1) << ST_ONE;
  localparam logic [7:0] ST_RESET = ONE_MASK | (8'(1) << ST_Z);

  typedef enum logic [3:0] {
    OP_ADC = 4'h0, OP_SBC = 4'h1, OP_CPA = 4'h2, OP_CPX = 4'h3,
    OP_ASL = 4'h4, OP_LSR = 4'h5, OP_ROL = 4'h6, OP_ROR = 4'h7,
    OP_BIT = 4'h8, OP_AND = 4'h9, OP_ORA = 4'hA, OP_EOR = 4'hB,
    OP_ARR = 4'hC, OP_AXS = 4'hD, OP_ASR = 4'hE, OP_LDM = 4'hF
  } alu_op_e;

  // one unit's answer: result, flag values, and which of C/V it defines
  typedef struct packed {
    logic [W-1:0] res;
    logic         c;
    logic         z;
    logic         n;
    logic         v;
    logic         wc;
    logic         wv;
  } alu_out_t;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output alu_out_t     out_o
);
  // one adder serves add, subtract, both compares and and-subtract
  function automatic logic [W:0] add_c(logic [W-1:0] p, logic [W-1:0] q, logic ci);
    return {1'b0, p} + {1'b0, q} + {{W{1'b0}}, ci};
  endfunction

  logic [W-1:0] lhs, rhs;
  logic         ci;
  logic [W:0]   sum;
  logic         ovf_w;   // signed overflow event
  logic         nob_w;   // carry out = no borrow on subtract forms

  always_comb begin
    lhs = a_i;
    rhs = m_i;
    ci  = cin_i;
    case (op_i)
      OP_SBC: rhs = ~m_i;
      OP_CPA: begin rhs = ~m_i; ci = 1'b1; end
      OP_CPX: begin lhs = x_i; rhs = ~m_i; ci = 1'b1; end
      OP_AXS: begin lhs = a_i & x_i; rhs = ~m_i; ci = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = add_c(lhs, rhs, ci);
  assign nob_w = sum[W];
  assign ovf_w = (lhs[MSB] == rhs[MSB]) && (sum[MSB] != lhs[MSB]);

  always_comb begin
    out_o.res = sum[W-1:0];
    if (op_i == OP_CPA) out_o.res = a_i;
    if (op_i == OP_CPX) out_o.res = x_i;
    out_o.c  = nob_w;
    out_o.z  = (sum[W-1:0] == '0);
    out_o.n  = sum[MSB];
    out_o.v  = ovf_w;
    out_o.wc = 1'b1;
    out_o.wv = (op_i == OP_ADC) || (op_i == OP_SBC);
  end

  // R1
  adc_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADC && a_i[MSB] == m_i[MSB]) |-> (out_o.v == (out_o.res[MSB] != a_i[MSB])));
  // R2
  sbc_same_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SBC && a_i[MSB] == m_i[MSB]) |-> !out_o.v);
  // R3
  cmp_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CPA) |-> (out_o.c == (a_i >= m_i) && out_o.res == a_i && !out_o.wv));
  // R8
  axs_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_AXS) |-> (out_o.c == ((a_i & x_i) >= m_i)));
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         cin_i,
  output alu_out_t     out_o
);
  logic         masked;   // source is A & M
  logic         left;
  logic         ins;      // bit shifted in
  logic [W-1:0] src;
  logic [W-1:0] shv;
  logic         out_bit;  // bit shifted out

  assign masked  = (op_i == OP_ARR) || (op_i == OP_ASR);
  assign left    = (op_i == OP_ASL) || (op_i == OP_ROL);
  assign ins     = cin_i & ((op_i == OP_ROL) || (op_i == OP_ROR) || (op_i == OP_ARR));
  assign src     = masked ? (a_i & m_i) : m_i;
  assign shv     = left ? {src[W-2:0], ins} : {ins, src[MSB:1]};
  assign out_bit = left ? src[MSB] : src[0];

  always_comb begin
    out_o.res = shv;
    out_o.z   = (shv == '0);
    out_o.n   = shv[MSB];
    out_o.wc  = 1'b1;
    out_o.c   = out_bit;
    out_o.v   = 1'b0;
    out_o.wv  = 1'b0;
    if (op_i == OP_ARR) begin
      out_o.c  = shv[W-2];
      out_o.v  = shv[W-2] ^ shv[W-3];
      out_o.wv = 1'b1;
    end
  end

  // R5
  shl_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ASL) |-> (out_o.c == m_i[MSB] && !out_o.res[0]));
  // R5
  ror_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ROR) |-> (out_o.res[MSB] == cin_i && out_o.c == m_i[0]));
  // R7
  arr_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ARR) |-> (out_o.res[MSB] == cin_i && out_o.wv));
  // R9
  asr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ASR) |-> (!out_o.n && out_o.c == (a_i[0] & m_i[0]) && !out_o.wv));
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  output alu_out_t     out_o
);
  logic         is_bit;
  logic [W-1:0] conj;
  logic [W-1:0] val;

  assign is_bit = (op_i == OP_BIT);
  assign conj   = a_i & m_i;

  always_comb begin
    case (op_i)
      OP_ORA:  val = a_i | m_i;
      OP_EOR:  val = a_i ^ m_i;
      OP_LDM:  val = m_i;
      OP_BIT:  val = a_i;
      default: val = conj;
    endcase
  end

  always_comb begin
    out_o.res = val;
    out_o.z   = is_bit ? (conj == '0) : (val == '0);
    out_o.n   = is_bit ? m_i[MSB] : val[MSB];
    out_o.v   = m_i[W-2];
    out_o.wv  = is_bit;
    out_o.c   = 1'b0;
    out_o.wc  = 1'b0;
  end

  // R4
  bit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bit |-> (out_o.res == a_i && !out_o.wc && out_o.n == m_i[MSB]));
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exec_i,
  input  logic       wr_i,
  input  logic [7:0] din_i,
  input  logic       c_i,
  input  logic       z_i,
  input  logic       n_i,
  input  logic       v_i,
  output logic [7:0] status_o,
  output logic       cin_o
);
  logic [7:0] st_q;
  logic       upd_w;   // execute update that is not overridden

  assign upd_w = exec_i && !wr_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q <= ST_RESET;
    end else if (wr_i) begin
      st_q <= din_i | ONE_MASK;
    end else if (exec_i) begin
      st_q[ST_C] <= c_i;
      st_q[ST_Z] <= z_i;
      st_q[ST_N] <= n_i;
      st_q[ST_V] <= v_i;
    end
  end

  assign status_o = st_q;
  assign cin_o    = st_q[ST_C];

  // R10
  one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) status_o[ST_ONE]);
  // R12
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (status_o == ($past(din_i) | ONE_MASK)));
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !exec_i) |=> $stable(status_o));
  // R11
  keep_idb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_w |=> (status_o[ST_B:ST_I] == $past(status_o[ST_B:ST_I])));
  // R11
  load_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_w |=> (status_o[ST_C] == $past(c_i) && status_o[ST_V] == $past(v_i)));
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] opnd_i,
  input  logic       exec_i,
  input  logic       st_wr_i,
  input  logic [7:0] st_din_i,
  output logic [7:0] result_o,
  output logic       c_o,
  output logic       z_o,
  output logic       n_o,
  output logic       v_o,
  output logic [7:0] status_o
);
  alu_op_e  op;
  logic     cin;
  alu_out_t ar_out, sh_out, lg_out, sel;
  logic     keeps_cv;   // op leaves C and V alone

  assign op = alu_op_e'(op_i);

  alu8_arith u_arith (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .a_i(acc_i), .x_i(idx_i),
    .m_i(opnd_i), .cin_i(cin), .out_o(ar_out));

  alu8_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .a_i(acc_i),
    .m_i(opnd_i), .cin_i(cin), .out_o(sh_out));

  alu8_logic u_logic (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .a_i(acc_i),
    .m_i(opnd_i), .out_o(lg_out));

  always_comb begin
    case (op)
      OP_ADC, OP_SBC, OP_CPA, OP_CPX, OP_AXS: sel = ar_out;
      OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_ARR, OP_ASR: sel = sh_out;
      default: sel = lg_out;
    endcase
  end

  assign result_o = sel.res;
  assign z_o      = sel.z;
  assign n_o      = sel.n;
  assign c_o      = sel.wc ? sel.c : cin;
  assign v_o      = sel.wv ? sel.v : status_o[ST_V];

  alu8_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .wr_i(st_wr_i),
    .din_i(st_din_i), .c_i(c_o), .z_i(z_o), .n_i(n_o), .v_i(v_o),
    .status_o(status_o), .cin_o(cin));

  assign keeps_cv = (op == OP_AND) || (op == OP_ORA) || (op == OP_EOR) || (op == OP_LDM);

  // R6
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keeps_cv |-> (c_o == status_o[ST_C] && v_o == status_o[ST_V]));
endmodule

// File: tb/alu8_status_bench.sv
`timescale 1ns/1ps
module alu8_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, idx = '0, opnd = '0, st_din = '0;
  logic       exec = 1'b0, st_wr = 1'b0;
  logic [7:0] result, status;
  logic       c_f, z_f, n_f, v_f;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  alu8_status u_alu8_status (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .idx_i(idx),
    .opnd_i(opnd), .exec_i(exec), .st_wr_i(st_wr), .st_din_i(st_din),
    .result_o(result), .c_o(c_f), .z_o(z_f), .n_o(n_f), .v_o(v_f),
    .status_o(status));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7: return "R5";
      8: return "R4";
      12: return "R7";
      13: return "R8";
      14: return "R9";
      default: return "R6";
    endcase
  endfunction

  // expected {result, C, Z, N, V} from integer arithmetic
  function automatic logic [11:0] model(int o, int a, int x, int m, int c, int v_old);
    int r = 0, cy = c, vv = v_old, s, t;
    logic zf, nf;
    logic zn_from_r = 1'b1;
    zf = 1'b0; nf = 1'b0;
    case (o)
      0: begin s = a + m + c; r = s & 255; cy = int'(s > 255);
               vv = int'(((a < 128) == (m < 128)) && ((r < 128) != (a < 128))); end
      1: begin s = a - m - (1 - c); r = s & 255; cy = int'(s >= 0);
               vv = int'(((a < 128) != (m < 128)) && ((r < 128) != (a < 128))); end
      2, 3: begin t = (o == 2) ? a : x; s = t - m; r = t; cy = int'(s >= 0);
               zn_from_r = 1'b0; zf = ((s & 255) == 0); nf = ((s & 255) >= 128); end
      4: begin r = (m * 2) & 255; cy = int'(m >= 128); end
      5: begin r = m / 2; cy = m % 2; end
      6: begin r = (m * 2 + c) & 255; cy = int'(m >= 128); end
      7: begin r = m / 2 + c * 128; cy = m % 2; end
      8: begin r = a; zn_from_r = 1'b0; zf = ((a & m) == 0); nf = (m >= 128); vv = (m / 64) % 2; end
      9: r = a & m;
      10: r = a | m;
      11: r = a ^ m;
      12: begin t = a & m; r = t / 2 + c * 128; cy = (r / 64) % 2;
                vv = int'(((r / 64) % 2) != ((r / 32) % 2)); end
      13: begin s = (a & x) - m; r = s & 255; cy = int'(s >= 0); end
      14: begin t = a & m; r = t / 2; cy = t % 2; end
      default: r = m;
    endcase
    if (zn_from_r) begin zf = (r == 0); nf = (r >= 128); end
    return {r[7:0], cy[0], zf, nf, vv[0]};
  endfunction

  task automatic set_status(logic [7:0] b);
    @(negedge clk);
    st_wr = 1'b1; st_din = b;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10", "reset status", {24'd0, status}, 32'h22);
  endtask

  task automatic t_bit5;
    set_status(8'h00);
    chk("R10", "bit5 forced", {24'd0, status}, 32'h20);
  endtask

  // every op, every A and M, under two status bytes
  task automatic t_sweep(logic [7:0] st);
    set_status(st);
    for (int o = 0; o < 16; o++) begin
      int bad = 0;
      for (int a = 0; a < 256; a++) begin
        for (int m = 0; m < 256; m++) begin
          logic [11:0] exp;
          op = 4'(o); acc = 8'(a); idx = 8'(a ^ 8'h5A); opnd = 8'(m);
          #1;
          exp = model(o, a, a ^ 8'h5A, m, int'(status[0]), int'(status[6]));
          n_chk++;
          if ({result, c_f, z_f, n_f, v_f} !== exp) begin
            n_err++;
            if (bad < 4)
              $display("FAIL %s op=%0d a=%h m=%h actual=%h expected=%h",
                       tag_of(o), o, a, m, {result, c_f, z_f, n_f, v_f}, exp);
            bad++;
          end
        end
      end
    end
  endtask

  task automatic t_exec_keep;
    set_status(8'h1C);
    @(negedge clk);
    op = 4'h0; acc = 8'h7F; opnd = 8'h01; exec = 1'b1;
    #1;
    chk("R1", "0x7F+1 comb", {20'd0, result, c_f, z_f, n_f, v_f}, {20'd0, 8'h80, 4'b0011});
    @(negedge clk);
    exec = 1'b0;
    chk("R11", "flags stored, I D B kept", {24'd0, status}, 32'hFC);
  endtask

  task automatic t_collide;
    @(negedge clk);
    op = 4'h0; acc = 8'hFF; opnd = 8'h01; exec = 1'b1; st_wr = 1'b1; st_din = 8'h03;
    @(negedge clk);
    exec = 1'b0; st_wr = 1'b0;
    chk("R12", "write wins over execute", {24'd0, status}, 32'h23);
  endtask

  task automatic t_hold;
    @(negedge clk);
    op = 4'hA; acc = 8'hFF; opnd = 8'h80;
    @(negedge clk);
    chk("R12", "idle hold", {24'd0, status}, 32'h23);
  endtask

  task automatic t_logic_keep;
    set_status(8'h41);
    @(negedge clk);
    op = 4'h9; acc = 8'hF0; opnd = 8'h0F; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
    chk("R6", "AND keeps C V", {24'd0, status}, 32'h63);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_bit5();
    t_exec_keep();
    t_collide();
    t_hold();
    t_logic_keep();
    t_sweep(8'h4C);   // C=0, V=1
    t_sweep(8'h91);   // C=1, V=0
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule